// File: doc/BRIEF.md
# Virtual-Channel Router Input Port

This block manages one input port of a packet router whose physical link is shared by several virtual channels (VCs). Arriving flits are tagged with the VC they belong to and with a kind: head, body, tail, or single-flit packet. Each VC has its own flit queue. A VC opens a packet when a head reaches the front of its queue. It first computes the output port from the destination coordinates in the head, using X-then-Y dimension order on a 2-D mesh. It then asks the external VC allocator for an output VC on that port. After that it asks the external switch allocator for a slot, one flit per slot. The flit that wins a slot leaves through a registered traversal stage.

Body and tail flits inherit the port and output VC chosen for their head. They only compete for switch slots. A tail flit releases the VC when it leaves, so the next head in the queue goes through route computation and VC allocation again. A credit counter for each downstream VC limits sending to the free buffer slots downstream. Each flit that leaves frees an input buffer slot, and the block reports that slot upstream as a credit. When the speculation mode pin is high, a head requests a switch slot while its VC request is still pending. If both grants arrive in the same cycle, the head leaves one cycle earlier. If only the switch grant arrives, that slot is wasted and the head retries.

Top module: `vcr_input_port`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `up_crd_valid`, `va_req` and `sa_req` are all low, every VC queue is empty, and every downstream credit counter holds the downstream depth (4).
- R2: The route is decided from the head flit's data: destination X in bits [3:0] and Y in bits [7:4], compared against the router position (5,5). The port codes are: X greater gives 1 (east), X smaller gives 2 (west), otherwise Y greater gives 3 (north), Y smaller gives 4 (south), and equal coordinates give 0 (local). The code appears on `req_port` while the VC waits for allocation, and on `out_port` for every flit of the packet.
- R3: Kind codes are 00 head, 01 body, 10 tail and 11 head-and-tail. A VC raises `va_req` starting in the cycle after its head reaches the queue front. It raises `va_req` only for a head, and holds it until `va_gnt`. Body and tail flits never cause a VC request, and they leave with the head's output VC.
- R4: Flits of one VC leave in arrival order, with their kind and data unchanged and with no flit lost or duplicated.
- R5: When a flit of kind 10 or 11 leaves, the VC returns to idle. The next packet on that VC repeats route computation and VC allocation.
- R6: With `spec_en` high, a VC waiting for allocation also raises `sa_req`. If `va_gnt` and `sa_gnt` arrive in the same cycle and the granted output VC has credit, the head leaves. If `sa_gnt` arrives without `va_gnt`, nothing leaves and the head keeps requesting.
- R7: With `spec_en` low, a head leaves only after its VC allocation has completed, so a flit never leaves in the same cycle as a VC grant.
- R8: There is one credit counter per downstream VC. It decrements when a flit leaves on that VC and increments on `crd_in_valid`. A VC whose output VC has zero credits does not raise `sa_req` and sends nothing.
- R9: Every flit that leaves produces exactly one upstream credit (`up_crd_valid`), tagged with the input VC it left from, in the same cycle as the flit output.
- R10: A flit granted by `sa_gnt` in cycle t appears on the output registers in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spec_en | input | 1 | Speculative allocation mode |
| in_valid | input | 1 | Incoming flit valid |
| in_vc | input | 2 | Input VC of the incoming flit |
| in_kind | input | 2 | Flit kind (00 head, 01 body, 10 tail, 11 head-and-tail) |
| in_data | input | 16 | Flit payload; the head carries destination X in [3:0] and Y in [7:4] |
| va_req | output | 4 | Per-VC request to the VC allocator |
| req_port | output | 12 | Per-VC output port, 3 bits per VC, VC 0 in the low bits |
| va_gnt | input | 4 | Per-VC grant from the VC allocator |
| va_ovc | input | 8 | Per-VC granted output VC, 2 bits per VC |
| sa_req | output | 4 | Per-VC request to the switch allocator |
| sa_gnt | input | 4 | Switch grant, at most one bit set |
| crd_in_valid | input | 1 | Credit returned by downstream |
| crd_in_vc | input | 2 | Downstream VC of the returned credit |
| out_valid | output | 1 | Outgoing flit valid |
| out_port | output | 3 | Output port of the outgoing flit |
| out_vc | output | 2 | Output VC of the outgoing flit |
| out_kind | output | 2 | Kind of the outgoing flit |
| out_data | output | 16 | Payload of the outgoing flit |
| up_crd_valid | output | 1 | Credit to upstream: an input slot was freed |
| up_crd_vc | output | 2 | Input VC whose slot was freed |

## Verification
The bench goes after the cases where a switch grant arrives without a VC grant in speculative mode. A design that let the head leave in that case would send a flit with no output VC. A design that dropped the head instead would lose a packet. It runs stretches with credit returns held back, where a counter that wrapped below zero or failed to block `sa_req` would push more flits than the downstream buffer holds. It mixes single-flit packets and back-to-back packets on the same VC, where a VC that did not release on the tail would send the next packet's head without route computation and with a stale port. It also compares every flit against a queue-based model, so any overtaking inside a VC, or a missing or extra upstream credit, shows up at once.

// File: rtl/vcr_pkg.sv
// vcr_pkg: shared constants, types and helpers for the VC input port.
// Assumes a 2-D mesh with 5 output directions and a 2-bit flit kind.
package vcr_pkg;

    localparam int PORT_W = 3;

    localparam logic [1:0] KIND_HEAD = 2'b00;
    localparam logic [1:0] KIND_BODY = 2'b01;
    localparam logic [1:0] KIND_TAIL = 2'b10;
    localparam logic [1:0] KIND_SOLO = 2'b11;

    localparam logic [PORT_W-1:0] DIR_LOCAL = 3'd0;
    localparam logic [PORT_W-1:0] DIR_EAST  = 3'd1;
    localparam logic [PORT_W-1:0] DIR_WEST  = 3'd2;
    localparam logic [PORT_W-1:0] DIR_NORTH = 3'd3;
    localparam logic [PORT_W-1:0] DIR_SOUTH = 3'd4;

    typedef enum logic [1:0] {
        VS_IDLE   = 2'd0,
        VS_ALLOC  = 2'd1,
        VS_ACTIVE = 2'd2
    } vc_state_e;

    // True when the kind starts a packet.
    function automatic logic kind_opens(input logic [1:0] k);
        return (k == KIND_HEAD) || (k == KIND_SOLO);
    endfunction

    // True when the kind ends a packet.
    function automatic logic kind_closes(input logic [1:0] k);
        return (k == KIND_TAIL) || (k == KIND_SOLO);
    endfunction

endpackage

// File: rtl/vcr_flit_fifo.sv
// vcr_flit_fifo: flit queue for one input VC.
// Assumes the upstream sender respects credits, so it never pushes while full.
// The front entry is visible one cycle after it is written.
module vcr_flit_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] front,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; slots need no reset.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Status and head-of-queue view.
    always_comb begin
        front = slots[rd_ptr];
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
    end

    // R4
    fifo_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/vcr_route_unit.sv
// vcr_route_unit: X-then-Y dimension-order route computation.
// Assumes the router sits at (MY_X, MY_Y); purely combinational.
module vcr_route_unit
    import vcr_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter int MY_X    = 5,
    parameter int MY_Y    = 5
) (
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    output logic [PORT_W-1:0]  dir
);
    localparam logic [COORD_W-1:0] HERE_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HERE_Y = COORD_W'(MY_Y);

    // Resolve X first, then Y, then eject locally.
    always_comb begin
        if (dest_x > HERE_X)      dir = DIR_EAST;
        else if (dest_x < HERE_X) dir = DIR_WEST;
        else if (dest_y > HERE_Y) dir = DIR_NORTH;
        else if (dest_y < HERE_Y) dir = DIR_SOUTH;
        else                      dir = DIR_LOCAL;
    end

endmodule

// File: rtl/vcr_vc_ctrl.sv
// vcr_vc_ctrl: per-VC packet state machine (idle, allocating, active).
// Assumes the queue front is a head whenever the VC is idle and not empty,
// and that the VC allocator holds va_ovc valid together with va_gnt.
module vcr_vc_ctrl
    import vcr_pkg::*;
#(
    parameter int OVC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_en,
    input  logic              fifo_empty,
    input  logic [1:0]        front_kind,
    input  logic [PORT_W-1:0] rc_dir,
    input  logic              va_gnt,
    input  logic [OVC_W-1:0]  va_ovc,
    input  logic              sa_gnt,
    input  logic              cred_ok_held,
    input  logic              cred_ok_new,
    output logic              va_req,
    output logic              sa_req,
    output logic              send,
    output logic [PORT_W-1:0] held_dir,
    output logic [OVC_W-1:0]  held_ovc,
    output logic [OVC_W-1:0]  send_ovc
);
    vc_state_e state;
    logic      active_ready;
    logic      spec_try;

    // Request and send decisions for this VC.
    always_comb begin
        active_ready = (state == VS_ACTIVE) && !fifo_empty && cred_ok_held;
        spec_try     = spec_en && (state == VS_ALLOC);
        va_req       = (state == VS_ALLOC);
        sa_req       = active_ready || spec_try;
        send         = sa_gnt && (active_ready || (spec_try && va_gnt && cred_ok_new));
        send_ovc     = (state == VS_ALLOC) ? va_ovc : held_ovc;
    end

    // State sequencing: route on head, allocate, stream until tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= VS_IDLE;
            held_dir <= DIR_LOCAL;
            held_ovc <= '0;
        end else begin
            case (state)
                VS_IDLE: begin
                    if (!fifo_empty && kind_opens(front_kind)) begin
                        held_dir <= rc_dir;
                        state    <= VS_ALLOC;
                    end
                end
                VS_ALLOC: begin
                    if (va_gnt) begin
                        held_ovc <= va_ovc;
                        state    <= (send && kind_closes(front_kind)) ? VS_IDLE : VS_ACTIVE;
                    end
                end
                VS_ACTIVE: begin
                    if (send && kind_closes(front_kind)) state <= VS_IDLE;
                end
                default: state <= VS_IDLE;
            endcase
        end
    end

    // R7
    alloc_send_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send && state == VS_ALLOC) |-> spec_en);

    // R5
    tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send && kind_closes(front_kind)) |=> (state == VS_IDLE));

    // R3
    idle_front_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VS_IDLE && !fifo_empty) |-> kind_opens(front_kind));

    // R6
    spec_no_send_without_va_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VS_ALLOC && !va_gnt) |-> !send);

endmodule

// File: rtl/vcr_credit_bank.sv
// vcr_credit_bank: one credit counter per downstream VC.
// Assumes downstream never returns more credits than it has buffer slots.
module vcr_credit_bank #(
    parameter int NUM_OVC  = 4,
    parameter int DN_DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       use_valid,
    input  logic [$clog2(NUM_OVC)-1:0] use_ovc,
    input  logic                       ret_valid,
    input  logic [$clog2(NUM_OVC)-1:0] ret_ovc,
    output logic [NUM_OVC-1:0]         avail
);
    localparam int OVC_W = $clog2(NUM_OVC);
    localparam int CNT_W = $clog2(DN_DEPTH + 1);

    logic [CNT_W-1:0] cnt [NUM_OVC];

    for (genvar g = 0; g < NUM_OVC; g++) begin : g_ctr
        logic dec;
        logic inc;
        // Per-counter decode of send and return events.
        always_comb begin
            dec = use_valid && (use_ovc == OVC_W'(g));
            inc = ret_valid && (ret_ovc == OVC_W'(g));
        end

        // Counter update: reset to downstream depth.
        always_ff @(posedge clk) begin
            if (!rst_n) cnt[g] <= CNT_W'(DN_DEPTH);
            else        cnt[g] <= cnt[g] + CNT_W'(inc) - CNT_W'(dec);
        end

        // Availability flag for this downstream VC.
        always_comb avail[g] = (cnt[g] != '0);

        // R8
        credit_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dec |-> (cnt[g] != '0));

        // R8
        credit_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && !dec) |-> (cnt[g] < CNT_W'(DN_DEPTH)));
    end

endmodule

// File: rtl/vcr_input_port.sv
// vcr_input_port: one router input port with NUM_VC virtual channels.
// Per VC: flit queue, route unit and state machine; shared credit bank and
// a registered switch-traversal stage. Assumes sa_gnt has at most one bit set
// and that upstream only sends into a VC with a free slot.
module vcr_input_port
    import vcr_pkg::*;
#(
    parameter int NUM_VC   = 4,
    parameter int VC_DEPTH = 4,
    parameter int NUM_OVC  = 4,
    parameter int DN_DEPTH = 4,
    parameter int FLIT_W   = 16,
    parameter int COORD_W  = 4,
    parameter int MY_X     = 5,
    parameter int MY_Y     = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         spec_en,
    input  logic                         in_valid,
    input  logic [$clog2(NUM_VC)-1:0]    in_vc,
    input  logic [1:0]                   in_kind,
    input  logic [FLIT_W-1:0]            in_data,
    output logic [NUM_VC-1:0]            va_req,
    output logic [NUM_VC*3-1:0]          req_port,
    input  logic [NUM_VC-1:0]            va_gnt,
    input  logic [NUM_VC*$clog2(NUM_OVC)-1:0] va_ovc,
    output logic [NUM_VC-1:0]            sa_req,
    input  logic [NUM_VC-1:0]            sa_gnt,
    input  logic                         crd_in_valid,
    input  logic [$clog2(NUM_OVC)-1:0]   crd_in_vc,
    output logic                         out_valid,
    output logic [2:0]                   out_port,
    output logic [$clog2(NUM_OVC)-1:0]   out_vc,
    output logic [1:0]                   out_kind,
    output logic [FLIT_W-1:0]            out_data,
    output logic                         up_crd_valid,
    output logic [$clog2(NUM_VC)-1:0]    up_crd_vc
);
    localparam int VC_W   = $clog2(NUM_VC);
    localparam int OVC_W  = $clog2(NUM_OVC);
    localparam int ENTRY_W = FLIT_W + 2;

    logic [ENTRY_W-1:0] front     [NUM_VC];
    logic [NUM_VC-1:0]  q_empty;
    logic [NUM_VC-1:0]  q_full;
    logic [NUM_VC-1:0]  send;
    logic [PORT_W-1:0]  held_dir  [NUM_VC];
    logic [OVC_W-1:0]   send_ovc  [NUM_VC];
    logic [NUM_OVC-1:0] avail;

    logic               any_send;
    logic [VC_W-1:0]    sel;
    logic [OVC_W-1:0]   sel_ovc;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        logic              push;
        logic [PORT_W-1:0] rc_dir;
        logic [OVC_W-1:0]  held_ovc;
        logic [OVC_W-1:0]  lane_ovc;
        logic              ok_held;
        logic              ok_new;

        // Input steering and credit lookups for this VC.
        always_comb begin
            push     = in_valid && (in_vc == VC_W'(v));
            lane_ovc = va_ovc[v*OVC_W +: OVC_W];
            ok_held  = avail[held_ovc];
            ok_new   = avail[lane_ovc];
            req_port[v*3 +: 3] = held_dir[v];
        end

        vcr_flit_fifo #(.WIDTH(ENTRY_W), .DEPTH(VC_DEPTH)) i_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push),
            .push_data ({in_kind, in_data}),
            .pop       (send[v]),
            .front     (front[v]),
            .empty     (q_empty[v]),
            .full      (q_full[v])
        );

        vcr_route_unit #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) i_route (
            .dest_x (front[v][COORD_W-1:0]),
            .dest_y (front[v][2*COORD_W-1:COORD_W]),
            .dir    (rc_dir)
        );

        vcr_vc_ctrl #(.OVC_W(OVC_W)) i_ctrl (
            .clk          (clk),
            .rst_n        (rst_n),
            .spec_en      (spec_en),
            .fifo_empty   (q_empty[v]),
            .front_kind   (front[v][ENTRY_W-1:FLIT_W]),
            .rc_dir       (rc_dir),
            .va_gnt       (va_gnt[v]),
            .va_ovc       (lane_ovc),
            .sa_gnt       (sa_gnt[v]),
            .cred_ok_held (ok_held),
            .cred_ok_new  (ok_new),
            .va_req       (va_req[v]),
            .sa_req       (sa_req[v]),
            .send         (send[v]),
            .held_dir     (held_dir[v]),
            .held_ovc     (held_ovc),
            .send_ovc     (send_ovc[v])
        );

        // R9
        no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (push && !send[v]) |-> !q_full[v]);
    end

    // Select the single sending VC.
    always_comb begin
        any_send = |send;
        sel      = '0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (send[v]) sel = VC_W'(v);
        end
        sel_ovc = send_ovc[sel];
    end

    vcr_credit_bank #(.NUM_OVC(NUM_OVC), .DN_DEPTH(DN_DEPTH)) i_credits (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_valid (any_send),
        .use_ovc   (sel_ovc),
        .ret_valid (crd_in_valid),
        .ret_ovc   (crd_in_vc),
        .avail     (avail)
    );

    // Switch traversal register and upstream credit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_port     <= DIR_LOCAL;
            out_vc       <= '0;
            out_kind     <= KIND_HEAD;
            out_data     <= '0;
            up_crd_valid <= 1'b0;
            up_crd_vc    <= '0;
        end else begin
            out_valid    <= any_send;
            up_crd_valid <= any_send;
            if (any_send) begin
                out_port  <= held_dir[sel];
                out_vc    <= sel_ovc;
                out_kind  <= front[sel][ENTRY_W-1:FLIT_W];
                out_data  <= front[sel][FLIT_W-1:0];
                up_crd_vc <= sel;
            end
        end
    end

    // R10
    sa_gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sa_gnt));

    // R10
    send_reaches_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_send |=> (out_valid && up_crd_valid));

    // R8
    send_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_send |-> |(sa_req & sa_gnt));

endmodule

// File: tb/test_vcr_input_port.sv
`timescale 1ns/1ps
// test_vcr_input_port: random traffic with a behavioural queue model
// compared on every clock.
module test_vcr_input_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        spec_en;
    logic        in_valid;
    logic [1:0]  in_vc;
    logic [1:0]  in_kind;
    logic [15:0] in_data;
    logic [3:0]  va_req;
    logic [11:0] req_port;
    logic [3:0]  va_gnt;
    logic [7:0]  va_ovc;
    logic [3:0]  sa_req;
    logic [3:0]  sa_gnt;
    logic        crd_in_valid;
    logic [1:0]  crd_in_vc;
    logic        out_valid;
    logic [2:0]  out_port;
    logic [1:0]  out_vc;
    logic [1:0]  out_kind;
    logic [15:0] out_data;
    logic        up_crd_valid;
    logic [1:0]  up_crd_vc;

    always #2 clk = ~clk;

    vcr_input_port i_vcr_input_port (.*);

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // Model state.
    logic [17:0] mq [4][$];
    int mst [4];
    int mport [4];
    int movc [4];
    int mcred [4];
    int pend [4];
    bit busy [4];
    int pkt_left [4];
    int serial = 0;
    int sent_in = 0;
    int sent_out = 0;
    bit e_valid = 0, e_up = 0;
    int e_port = 0, e_vc = 0, e_kind = 0, e_data = 0, e_upvc = 0;

    function automatic int route(input int x, input int y);
        if (x > 5) return 1;
        if (x < 5) return 2;
        if (y > 5) return 3;
        if (y < 5) return 4;
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cycles);
        end
    endtask

    function automatic bit m_sa_req(input int v);
        return (mst[v] == 2 && mq[v].size() > 0 && mcred[movc[v]] > 0) ||
               (spec_en && mst[v] == 1);
    endfunction

    // Compare all outputs against the model, then choose inputs and step it.
    task automatic cycle_step(input bit feed, input int crd_prob);
        int snd;
        int sovc;
        int gv;
        logic [17:0] fr;
        logic [3:0] exp_va, exp_sa;
        exp_va = '0; exp_sa = '0;
        for (int v = 0; v < 4; v++) begin
            exp_va[v] = (mst[v] == 1);
            exp_sa[v] = m_sa_req(v);
        end
        // R4 R10 flit output timing and content
        check(out_valid == e_valid, "R4 R10 out_valid", out_valid, e_valid);
        if (e_valid) begin
            check({out_kind, out_data} == {e_kind[1:0], e_data[15:0]}, "R4 flit order/content",
                  {out_kind, out_data}, {e_kind[1:0], e_data[15:0]});
            check(out_port == e_port[2:0], "R2 out_port", out_port, e_port);
            check(out_vc == e_vc[1:0], "R3 out_vc inherited", out_vc, e_vc);
        end
        // R9 upstream credit
        check(up_crd_valid == e_up && (!e_up || up_crd_vc == e_upvc[1:0]),
              "R9 upstream credit", {up_crd_valid, up_crd_vc}, {e_up, e_upvc[1:0]});
        // R3 R5 VC requests only for heads, renewed after tail
        check(va_req == exp_va, "R3 R5 va_req", va_req, exp_va);
        // R6 R7 R8 switch requests
        check(sa_req == exp_sa, spec_en ? "R6 R8 sa_req" : "R7 R8 sa_req", sa_req, exp_sa);
        for (int v = 0; v < 4; v++) begin
            if (mst[v] == 1)
                check(req_port[v*3 +: 3] == mport[v][2:0], "R2 req_port", req_port[v*3 +: 3], mport[v]);
        end

        // Choose allocator grants.
        va_gnt = '0; gv = -1;
        for (int o = 0; o < 4; o++) if (!busy[o] && gv < 0) gv = o;
        if (gv >= 0 && ($urandom % 2) == 0) begin
            int start;
            start = $urandom % 4;
            for (int k = 0; k < 4; k++) begin
                int v;
                v = (start + k) % 4;
                if (mst[v] == 1 && va_gnt == '0) va_gnt[v] = 1'b1;
            end
            if (va_gnt != '0) busy[gv] = 1;
        end
        if (gv < 0) gv = 0;
        va_ovc = {4{gv[1:0]}};
        sa_gnt = '0;
        if (($urandom % 4) != 0) begin
            int start;
            start = $urandom % 4;
            for (int k = 0; k < 4; k++) begin
                int v;
                v = (start + k) % 4;
                if (exp_sa[v] && sa_gnt == '0) sa_gnt[v] = 1'b1;
            end
        end
        // Downstream credit return.
        crd_in_valid = 0; crd_in_vc = 0;
        if (($urandom % 100) < crd_prob) begin
            int start;
            start = $urandom % 4;
            for (int k = 0; k < 4; k++) begin
                int o;
                o = (start + k) % 4;
                if (pend[o] > 0 && !crd_in_valid) begin
                    crd_in_valid = 1; crd_in_vc = o[1:0];
                end
            end
        end
        // Upstream flit.
        in_valid = 0; in_vc = 0; in_kind = 0; in_data = 0;
        if (feed && ($urandom % 2) == 0) begin
            int v;
            v = $urandom % 4;
            if (mq[v].size() < 4) begin
                in_valid = 1; in_vc = v[1:0];
                if (pkt_left[v] == 0) begin
                    pkt_left[v] = 1 + ($urandom % 4);
                    in_kind = (pkt_left[v] == 1) ? 2'b11 : 2'b00;
                    in_data = {serial[7:0], 4'($urandom % 16), 4'($urandom % 16)};
                end else begin
                    in_kind = (pkt_left[v] == 1) ? 2'b10 : 2'b01;
                    in_data = {serial[7:0], 8'($urandom)};
                end
                pkt_left[v]--;
                serial++;
                sent_in++;
            end
        end

        // Model step.
        snd = -1; sovc = 0;
        for (int v = 0; v < 4; v++) begin
            if (sa_gnt[v]) begin
                if (mst[v] == 2 && mq[v].size() > 0 && mcred[movc[v]] > 0) begin
                    snd = v; sovc = movc[v];
                end else if (spec_en && mst[v] == 1 && va_gnt[v] && mcred[gv] > 0) begin
                    snd = v; sovc = gv;
                end
            end
        end
        e_valid = (snd >= 0);
        e_up    = (snd >= 0);
        if (snd >= 0) begin
            fr = mq[snd][0];
            e_port = mport[snd]; e_vc = sovc;
            e_kind = fr[17:16]; e_data = fr[15:0]; e_upvc = snd;
        end
        for (int v = 0; v < 4; v++) begin
            bit closes;
            closes = (snd == v) && mq[v][0][17];
            case (mst[v])
                0: if (mq[v].size() > 0 && (mq[v][0][17:16] == 2'b00 || mq[v][0][17:16] == 2'b11)) begin
                       mst[v] = 1;
                       mport[v] = route(int'(mq[v][0][3:0]), int'(mq[v][0][7:4]));
                   end
                1: begin
                       if (va_gnt[v]) begin movc[v] = gv; mst[v] = 2; end
                       if (closes) mst[v] = 0;
                   end
                default: if (closes) mst[v] = 0;
            endcase
        end
        if (snd >= 0) begin
            mcred[sovc]--;
            pend[sovc]++;
            if (mq[snd][0][17]) busy[sovc] = 0;
            void'(mq[snd].pop_front());
            sent_out++;
        end
        if (crd_in_valid) begin
            mcred[crd_in_vc]++;
            pend[crd_in_vc]--;
        end
        if (in_valid) mq[in_vc].push_back({in_kind, in_data});
    endtask

    initial begin
        rst_n = 0; spec_en = 0; in_valid = 0; in_vc = 0; in_kind = 0; in_data = 0;
        va_gnt = 0; va_ovc = 0; sa_gnt = 0; crd_in_valid = 0; crd_in_vc = 0;
        for (int v = 0; v < 4; v++) begin
            mst[v] = 0; mport[v] = 0; movc[v] = 0; mcred[v] = 4;
            pend[v] = 0; busy[v] = 0; pkt_left[v] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(out_valid == 0 && up_crd_valid == 0, "R1 outputs idle after reset",
              {out_valid, up_crd_valid}, 0);
        check(va_req == 0 && sa_req == 0, "R1 no requests after reset", {va_req, sa_req}, 0);
        rst_n = 1;
        // R7 non-speculative traffic
        spec_en = 0;
        for (int c = 0; c < 3000; c++) begin @(negedge clk); cycle_step(1, 70); end
        // R6 speculative traffic
        spec_en = 1;
        for (int c = 0; c < 3000; c++) begin @(negedge clk); cycle_step(1, 70); end
        // R8 credit starvation, both modes
        for (int c = 0; c < 1500; c++) begin @(negedge clk); cycle_step(1, 8); end
        spec_en = 0;
        for (int c = 0; c < 1500; c++) begin @(negedge clk); cycle_step(1, 8); end
        // Drain, flushing partial packets: R5 release after each tail
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            cycle_step(c < 200 || pkt_left[0] + pkt_left[1] + pkt_left[2] + pkt_left[3] > 0, 90);
        end
        @(negedge clk);
        check(sent_out == sent_in, "R4 every flit delivered", sent_out, sent_in);
        check(va_req == 0 && sa_req == 0, "R5 all VCs released", {va_req, sa_req}, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Cycle counter.
    always @(posedge clk) cycles <= cycles + 1;

    // Watchdog.
    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule